// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit with HI/LO Result Pair

This block performs 32-bit multiplication and division one bit per clock and keeps its results in two dedicated result registers, HI and LO. A core issues a command by pulsing a valid strobe with a 6-bit function code and two operands. The unit then works for a fixed number of cycles with its busy flag raised, and at the end writes both result registers in the same clock. Products fill the pair as a 64-bit value (upper half in HI). Divisions put the quotient in LO and the remainder in HI. Signed and unsigned forms share the datapath and differ only in how the operands are read.

A separate read port moves HI or LO to the register write path. Reads are interlocked: a read asked for while the unit is busy raises a stall output until the operation ends, and the value returned then is the new result. Division by zero takes the normal time and produces a fixed result without any flag.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, busy and mv_stall are low and both HI and LO read as zero.
- R2: A command with function code 0x18, 0x19, 0x1A or 0x1B accepted while idle raises busy from the next clock for exactly 32 clocks. HI and LO are written on the edge where busy falls.
- R3: Code 0x19 multiplies the operands as unsigned numbers. HI receives bits 63..32 of the product and LO bits 31..0.
- R4: Code 0x18 multiplies the operands as two's complement numbers, with the same split of the 64-bit product between HI and LO.
- R5: Code 0x1B divides the operands as unsigned numbers, with the quotient in LO and the remainder in HI.
- R6: Code 0x1A divides the operands as two's complement numbers. The quotient is truncated toward zero and the remainder takes the sign of the dividend. LO holds the low 32 bits of the quotient, so 0x80000000 divided by -1 gives LO = 0x80000000 and HI = 0.
- R7: A divide by zero, signed or unsigned, takes the normal 32 clocks and leaves HI equal to the dividend and LO = 0xFFFFFFFF.
- R8: While idle, a read with code 0x10 returns HI and a read with code 0x12 returns LO in the same cycle, with mv_stall low.
- R9: A read with code 0x10 or 0x12 made while busy holds mv_stall high until busy falls. In the first cycle after that, the read returns the newly written value with mv_stall low.
- R10: A command strobe is ignored when the unit is busy or when its code is not one of 0x18 to 0x1B. It does not start an operation or change HI or LO, and a running operation keeps its operands and its end time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command strobe, one cycle |
| op_func | input | 6 | Function code of the command |
| op_a | input | 32 | First operand (multiplicand or dividend) |
| op_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | High while an operation is running |
| mv_valid | input | 1 | Read request for HI or LO |
| mv_func | input | 6 | Read code: 0x10 for HI, 0x12 for LO |
| mv_stall | output | 1 | Read must wait; hold the request |
| mv_data | output | 32 | Selected result register, zero for other codes |

## Verification
A wrong iteration count or a stuck sequencer shows at the ports as a busy window of the wrong length, and the bench catches it on the falling edge of busy, 32 clocks after issue. A bad partial product, remainder or sign fixup stays hidden while busy, because reads stall then. It shows in the first idle read of HI or LO after completion. A spurious start or a missed interlock shows either as an extra busy window with no pending expectation or as mv_stall low during a busy cycle. Each is visible within one cycle of the event.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam int DW    = 32;
  localparam int STEPS = DW;
  localparam int CW    = $clog2(STEPS);
  localparam int FW    = 6;

  localparam logic [FW-1:0] FN_RD_HI = 6'h10;
  localparam logic [FW-1:0] FN_RD_LO = 6'h12;
  localparam logic [FW-1:0] FN_MUL_S = 6'h18;
  localparam logic [FW-1:0] FN_MUL_U = 6'h19;
  localparam logic [FW-1:0] FN_DIV_S = 6'h1A;
  localparam logic [FW-1:0] FN_DIV_U = 6'h1B;

  typedef logic [DW-1:0]   word_t;
  typedef logic [2*DW-1:0] dword_t;

  typedef struct packed {
    logic valid;
    logic is_mul;
    logic is_signed;
  } arith_dec_t;

  // absolute value when the operand is read as signed
  function automatic word_t magnitude(word_t v, logic sgn);
    return (sgn && v[DW-1]) ? word_t'(-v) : v;
  endfunction

  function automatic word_t cond_neg(word_t v, logic n);
    return n ? word_t'(-v) : v;
  endfunction

  function automatic dword_t cond_neg_d(dword_t v, logic n);
    return n ? dword_t'(-v) : v;
  endfunction

  // one shift-and-add step: acc = {partial high, multiplier remainder}
  function automatic dword_t mul_step(dword_t acc, word_t mcand);
    logic [DW:0] sum;
    sum = {1'b0, acc[2*DW-1:DW]} + {1'b0, (acc[0] ? mcand : word_t'(0))};
    return {sum, acc[DW-1:1]};
  endfunction

  // one restoring step: acc = {remainder, dividend bits / quotient bits}
  function automatic dword_t div_step(dword_t acc, word_t dsor);
    logic [DW:0]   shifted;
    logic [DW+1:0] trial;
    word_t         rem;
    logic          qbit;
    shifted = {acc[2*DW-1:DW], acc[DW-1]};
    trial   = {1'b0, shifted} - {2'b00, dsor};
    if (trial[DW+1]) begin
      rem  = shifted[DW-1:0];
      qbit = 1'b0;
    end else begin
      rem  = trial[DW-1:0];
      qbit = 1'b1;
    end
    return {rem, acc[DW-2:0], qbit};
  endfunction

endpackage

// File: rtl/muldiv_dec.sv
module muldiv_dec
  import muldiv_pkg::*;
(
  input  logic [FW-1:0] op_func,
  input  logic [FW-1:0] mv_func,
  output arith_dec_t    dec,
  output logic          rd_hi,
  output logic          rd_lo
);

  always_comb begin
    dec = '0;
    case (op_func)
      FN_MUL_S: dec = '{valid: 1'b1, is_mul: 1'b1, is_signed: 1'b1};
      FN_MUL_U: dec = '{valid: 1'b1, is_mul: 1'b1, is_signed: 1'b0};
      FN_DIV_S: dec = '{valid: 1'b1, is_mul: 1'b0, is_signed: 1'b1};
      FN_DIV_U: dec = '{valid: 1'b1, is_mul: 1'b0, is_signed: 1'b0};
      default:  dec = '0;
    endcase
  end

  assign rd_hi = (mv_func == FN_RD_HI);
  assign rd_lo = (mv_func == FN_RD_LO);

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy,
  output logic finish
);

  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign finish = busy && (cnt == LAST);

endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
  import muldiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       busy,
  input  arith_dec_t dec,
  input  word_t      op_a,
  input  word_t      op_b,
  output word_t      res_hi,
  output word_t      res_lo
);

  dword_t acc;
  word_t  oper;
  word_t  dvd_keep;
  logic   mode_mul;
  logic   neg_main;
  logic   neg_rem;
  logic   div_zero;

  dword_t acc_nx;
  dword_t prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      oper     <= '0;
      dvd_keep <= '0;
      mode_mul <= 1'b0;
      neg_main <= 1'b0;
      neg_rem  <= 1'b0;
      div_zero <= 1'b0;
    end else if (accept) begin
      acc      <= {word_t'(0), magnitude(op_a, dec.is_signed)};
      oper     <= magnitude(op_b, dec.is_signed);
      dvd_keep <= op_a;
      mode_mul <= dec.is_mul;
      neg_main <= dec.is_signed && (op_a[DW-1] ^ op_b[DW-1]);
      neg_rem  <= dec.is_signed && op_a[DW-1];
      div_zero <= (op_b == word_t'(0));
    end else if (busy) begin
      acc <= acc_nx;
    end
  end

  assign acc_nx = mode_mul ? mul_step(acc, oper) : div_step(acc, oper);
  assign prod   = cond_neg_d(acc_nx, neg_main);

  always_comb begin
    if (mode_mul) begin
      res_hi = prod[2*DW-1:DW];
      res_lo = prod[DW-1:0];
    end else if (div_zero) begin
      res_hi = dvd_keep;
      res_lo = '1;
    end else begin
      res_hi = cond_neg(acc_nx[2*DW-1:DW], neg_rem);
      res_lo = cond_neg(acc_nx[DW-1:0], neg_main);
    end
  end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  finish,
  input  word_t res_hi,
  input  word_t res_lo,
  input  logic  busy,
  input  logic  mv_valid,
  input  logic  rd_hi,
  input  logic  rd_lo,
  output word_t hi_q,
  output word_t lo_q,
  output word_t mv_data,
  output logic  mv_stall
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (finish) begin
      hi_q <= res_hi;
      lo_q <= res_lo;
    end
  end

  assign mv_data  = rd_hi ? hi_q : (rd_lo ? lo_q : word_t'(0));
  assign mv_stall = mv_valid && busy && (rd_hi || rd_lo);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [FW-1:0] op_func,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          busy,
  input  logic          mv_valid,
  input  logic [FW-1:0] mv_func,
  output logic          mv_stall,
  output logic [DW-1:0] mv_data
);

  arith_dec_t dec;
  logic       rd_hi;
  logic       rd_lo;
  logic       accept;
  logic       finish;
  word_t      res_hi;
  word_t      res_lo;
  word_t      hi_q;
  word_t      lo_q;

  muldiv_dec u_dec (
    .op_func (op_func),
    .mv_func (mv_func),
    .dec     (dec),
    .rd_hi   (rd_hi),
    .rd_lo   (rd_lo)
  );

  assign accept = op_valid && dec.valid && !busy;

  muldiv_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .busy   (busy),
    .finish (finish)
  );

  muldiv_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .busy   (busy),
    .dec    (dec),
    .op_a   (op_a),
    .op_b   (op_b),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  muldiv_hilo u_hilo (
    .clk      (clk),
    .rst_n    (rst_n),
    .finish   (finish),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .busy     (busy),
    .mv_valid (mv_valid),
    .rd_hi    (rd_hi),
    .rd_lo    (rd_lo),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .mv_data  (mv_data),
    .mv_stall (mv_stall)
  );

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        finish,
  input logic        busy,
  input logic        mv_valid,
  input logic        mv_stall,
  input logic [31:0] hi_q,
  input logic [31:0] lo_q
);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> ($stable(hi_q) && $stable(lo_q)));

  // R9
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mv_stall) && mv_valid) |-> !busy);

  // R9
  stall_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_stall |-> busy);

endmodule

bind muldiv_unit muldiv_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .finish   (finish),
  .busy     (busy),
  .mv_valid (mv_valid),
  .mv_stall (mv_stall),
  .hi_q     (hi_q),
  .lo_q     (lo_q)
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [5:0]  op_func = 6'h00;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        busy;
  logic        mv_valid = 1'b1;
  logic [5:0]  mv_func = 6'h10;
  logic        mv_stall;
  logic [31:0] mv_data;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  muldiv_unit uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_func  (op_func),
    .op_a     (op_a),
    .op_b     (op_b),
    .busy     (busy),
    .mv_valid (mv_valid),
    .mv_func  (mv_func),
    .mv_stall (mv_stall),
    .mv_data  (mv_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference arithmetic, written from the requirements
  task automatic model(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] hi, output logic [31:0] lo);
    longint sa, sb, sq, sr;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    hi = '0;
    lo = '0;
    case (fn)
      6'h19: begin p = {32'b0, a} * {32'b0, b}; hi = p[63:32]; lo = p[31:0]; end
      6'h18: begin p = 64'(sa * sb); hi = p[63:32]; lo = p[31:0]; end
      6'h1B: begin
        if (b == 0) begin hi = a; lo = '1; end
        else begin hi = a % b; lo = a / b; end
      end
      6'h1A: begin
        if (b == 0) begin hi = a; lo = '1; end
        else begin sq = sa / sb; sr = sa % sb; hi = sr[31:0]; lo = sq[31:0]; end
      end
      default: ;
    endcase
  endtask

  // driver: pushes the expectation, pulses the command, waits for idle
  task automatic issue(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                       input string tag, input bit poke_busy);
    exp_t e;
    model(fn, a, b, e.hi, e.lo);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    op_valid = 1'b1; op_func = fn; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0; op_a = '0; op_b = '0;
    if (poke_busy) begin
      repeat (4) @(negedge clk);
      // R10: a new command while busy must be dropped
      op_valid = 1'b1; op_func = 6'h19; op_a = 32'h1234; op_b = 32'h5678;
      @(negedge clk);
      op_valid = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  // monitor: checks the busy window, the interlock and the results
  initial begin : monitor
    int   busy_len;
    logic prev_busy;
    exp_t e;
    busy_len  = 0;
    prev_busy = 1'b0;
    wait (rst_n);
    @(negedge clk);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 stall", {31'b0, mv_stall}, 32'd0);
    check("R1 HI", mv_data, 32'd0);
    mv_func = 6'h12; #1;
    check("R1 LO", mv_data, 32'd0);
    mv_func = 6'h10;
    forever begin
      @(negedge clk);
      if (busy) begin
        busy_len++;
        if (busy_len == 1 || busy_len == 32)
          check("R9 stall while busy", {31'b0, mv_stall}, 32'd1);
      end else if (prev_busy) begin
        check("R2 busy length", 32'(busy_len), 32'd32);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 actual=unexpected completion expected=none");
        end else begin
          e = exp_q.pop_front();
          check("R9 stall released", {31'b0, mv_stall}, 32'd0);
          check({e.tag, " HI"}, mv_data, e.hi);
          mv_func = 6'h12; #1;
          check("R8 LO read idle no stall", {31'b0, mv_stall}, 32'd0);
          check({e.tag, " LO"}, mv_data, e.lo);
          mv_func = 6'h10;
        end
        busy_len = 0;
      end
      prev_busy = busy;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(6'h19, 32'd3, 32'd5, "R3", 1'b0);
    issue(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3", 1'b0);
    issue(6'h18, 32'hFFFF_FFF9, 32'd6, "R4", 1'b0);
    issue(6'h18, 32'h8000_0000, 32'h8000_0000, "R4", 1'b0);
    issue(6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4", 1'b0);
    issue(6'h1B, 32'd100, 32'd7, "R5", 1'b0);
    issue(6'h1B, 32'hFFFF_FFFF, 32'd1, "R5", 1'b0);
    issue(6'h1A, 32'hFFFF_FFF9, 32'd2, "R6", 1'b0);
    issue(6'h1A, 32'd7, 32'hFFFF_FFFE, "R6", 1'b0);
    issue(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, "R6", 1'b0);
    issue(6'h1B, 32'd5, 32'd0, "R7", 1'b0);
    issue(6'h1A, 32'hFFFF_FFF7, 32'd0, "R7", 1'b0);
    issue(6'h1B, 32'hDEAD_BEEF, 32'h0000_1000, "R10", 1'b1);

    // R10: codes outside the arithmetic set must not start anything
    @(negedge clk);
    op_valid = 1'b1; op_func = 6'h10; op_a = 32'd9; op_b = 32'd9;
    @(negedge clk);
    op_valid = 1'b0;
    check("R10 read code ignored", {31'b0, busy}, 32'd0);
    op_valid = 1'b1; op_func = 6'h1C;
    @(negedge clk);
    op_valid = 1'b0;
    check("R10 unknown code ignored", {31'b0, busy}, 32'd0);
    repeat (3) @(negedge clk);

    check("R2 queue drained", 32'(exp_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule